// File: doc/BRIEF.md
# Predicate Branch Condition Evaluator

This block sits in a shader sequencer's control path and judges conditional branches. It takes one 64-bit control word together with the predicate register of every fiber (four one-bit components per fiber, called x, y, z and w) and the active-fiber mask. It then states whether the branch is taken, which fibers take it, and where it goes. The word is recognised as a predicate branch by a fixed opcode pattern. A 3-bit type field then selects how the per-fiber condition is formed and reduced.

There are three single-source types: per fiber, any fiber and all fibers. There are also two dual-source types, which combine two independently inverted components by OR or by AND. Type values outside these five are flagged as illegal. Fetching the target and keeping divergence state belong to neighbouring blocks.

Words enter on a valid/ready input stream and results leave on a valid/ready output stream, through a single register stage. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output slot is empty or is being drained in that same cycle. This lets one word per cycle flow under continuous `out_ready`. While `out_valid` is high and `out_ready` is low, the result holds steady and no new word is taken. The upstream side may hold or drop `in_valid` as it likes.

Top module: `predicate_branch_eval`

## Requirements
- R1: After reset `out_valid` is 0.
- R2: `in_ready` equals (not `out_valid`) or `out_ready`. A word accepted at an edge is presented with `out_valid` high after that edge. While `out_valid` is high and `out_ready` low, every output holds its value.
- R3: A word is a predicate branch only when bits 63:61 are 000, bit 49 is 0 and bits 58:55 are 0001. Any other word yields taken 0, mask 0 and illegal 0.
- R4: Predicate input bit 4*f+c is component c of fiber f (c = 0 x, 1 y, 2 z, 3 w). For source A, bits 54:53 select the component and bit 52 inverts it. The condition of fiber f is the selected bit XOR the invert bit.
- R5: Type 000 (bits 39:37), per fiber: mask = condA AND active, and taken = mask is nonzero.
- R6: Type 100, any fiber: taken when condA holds for at least one active fiber. The mask is then the whole active mask, otherwise 0.
- R7: Type 101, all fibers: taken when condA holds for every active fiber and at least one fiber is active. The mask is then the whole active mask, otherwise 0. Inactive fibers do not matter.
- R8: Type 001, dual OR: source B's component is selected by bits 47:46 and inverted by bit 45. mask = (condA OR condB) AND active, and taken = mask nonzero.
- R9: Type 010, dual AND: mask = (condA AND condB) AND active, and taken = mask nonzero.
- R10: A branch word whose type is 011, 110, 111 or any other value not listed above gives illegal 1, taken 0 and mask 0.
- R11: The target output equals bits 31:0 of the accepted word, for every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_instr | input | 64 | Control word |
| in_pred | input | 4*NFIB | Predicate components, four per fiber |
| in_active | input | NFIB | Active-fiber mask |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_taken | output | 1 | Branch taken |
| out_mask | output | NFIB | Fibers that take the branch |
| out_target | output | 32 | Branch target immediate |
| out_illegal | output | 1 | Branch word with an unevaluated type |

## Verification
The hardest case to reach is an all-fibers branch that is taken while some inactive fibers disagree. Random predicate bits almost never line up across sixteen fibers. The stimulus therefore often forces the selected component of every fiber to satisfy the condition, then clears it on inactive fibers, so that the taken path and the role of the active mask are both exercised. Stalls are produced by dropping `out_ready` at random while new words wait, which drives the hold rule and the accept-on-drain case. An empty active mask is applied directly to the any and all types.

// File: rtl/pbe_pkg.sv
package pbe_pkg;

  localparam int INSTR_W = 64;
  localparam int TGT_W   = 32;
  localparam int COMPS   = 4;
  localparam int SEL_W   = $clog2(COMPS);

  // Field positions that the branch encoding fixes
  localparam int CLASS_LO  = 61;
  localparam int OPC_LO    = 55;
  localparam int OPC_HI0   = 49;
  localparam int KIND_LO   = 37;
  localparam int A_INV_BIT = 52;
  localparam int A_SEL_LO  = 53;
  localparam int B_INV_BIT = 45;
  localparam int B_SEL_LO  = 46;

  localparam logic [2:0] CLASS_CODE = 3'b000;
  localparam logic [3:0] OPC_CODE   = 4'b0001;

  typedef enum logic [2:0] {
    KIND_LANE = 3'b000,
    KIND_OR   = 3'b001,
    KIND_AND  = 3'b010,
    KIND_ANY  = 3'b100,
    KIND_ALL  = 3'b101
  } kind_e;

  typedef struct packed {
    logic             is_branch;
    logic [2:0]       kind_raw;
    logic             inv_a;
    logic [SEL_W-1:0] sel_a;
    logic             inv_b;
    logic [SEL_W-1:0] sel_b;
    logic [TGT_W-1:0] target;
  } br_fields_t;

endpackage

// File: rtl/pbe_decode.sv
module pbe_decode
  import pbe_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output br_fields_t         fields
);

  logic class_hit;
  logic opc_hit;

  assign class_hit = (instr[CLASS_LO +: 3] == CLASS_CODE);
  assign opc_hit   = (instr[OPC_LO +: 4] == OPC_CODE) && !instr[OPC_HI0];

  always_comb begin
    fields           = '0;
    fields.is_branch = class_hit && opc_hit;
    fields.kind_raw  = instr[KIND_LO +: 3];
    fields.inv_a     = instr[A_INV_BIT];
    fields.sel_a     = instr[A_SEL_LO +: SEL_W];
    fields.inv_b     = instr[B_INV_BIT];
    fields.sel_b     = instr[B_SEL_LO +: SEL_W];
    fields.target    = instr[TGT_W-1:0];
  end

  // Bits that carry no meaning for condition evaluation
  logic unused_bits;
  assign unused_bits = ^{instr[36:32], instr[44:40], instr[48],
                         instr[51:50], instr[60:59]};

endmodule

// File: rtl/pbe_lane_cond.sv
module pbe_lane_cond
  import pbe_pkg::*;
#(
  parameter int NFIB = 16
) (
  input  logic [COMPS*NFIB-1:0] pred,
  input  logic                  inv_a,
  input  logic [SEL_W-1:0]      sel_a,
  input  logic                  inv_b,
  input  logic [SEL_W-1:0]      sel_b,
  output logic [NFIB-1:0]       cond_a,
  output logic [NFIB-1:0]       cond_b
);

  for (genvar f = 0; f < NFIB; f++) begin : g_fiber
    logic [COMPS-1:0] comps;
    assign comps     = pred[f*COMPS +: COMPS];
    assign cond_a[f] = comps[sel_a] ^ inv_a;
    assign cond_b[f] = comps[sel_b] ^ inv_b;
  end

endmodule

// File: rtl/pbe_reduce.sv
module pbe_reduce
  import pbe_pkg::*;
#(
  parameter int NFIB = 16
) (
  input  logic            is_branch,
  input  logic [2:0]      kind_raw,
  input  logic [NFIB-1:0] cond_a,
  input  logic [NFIB-1:0] cond_b,
  input  logic [NFIB-1:0] active,
  output logic            taken,
  output logic [NFIB-1:0] mask,
  output logic            illegal
);

  logic [NFIB-1:0] lane_m;
  logic [NFIB-1:0] or_m;
  logic [NFIB-1:0] and_m;
  logic            any_hit;
  logic            all_hit;

  assign lane_m  = cond_a & active;
  assign or_m    = (cond_a | cond_b) & active;
  assign and_m   = (cond_a & cond_b) & active;
  assign any_hit = |lane_m;
  assign all_hit = (|active) && (&(cond_a | ~active));

  always_comb begin
    taken   = 1'b0;
    mask    = '0;
    illegal = 1'b0;
    if (is_branch) begin
      case (kind_raw)
        KIND_LANE: begin
          mask  = lane_m;
          taken = any_hit;
        end
        KIND_OR: begin
          mask  = or_m;
          taken = |or_m;
        end
        KIND_AND: begin
          mask  = and_m;
          taken = |and_m;
        end
        KIND_ANY: begin
          taken = any_hit;
          mask  = any_hit ? active : '0;
        end
        KIND_ALL: begin
          taken = all_hit;
          mask  = all_hit ? active : '0;
        end
        default: illegal = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/predicate_branch_eval.sv
module predicate_branch_eval
  import pbe_pkg::*;
#(
  parameter int NFIB = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [INSTR_W-1:0]    in_instr,
  input  logic [COMPS*NFIB-1:0] in_pred,
  input  logic [NFIB-1:0]       in_active,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  out_taken,
  output logic [NFIB-1:0]       out_mask,
  output logic [TGT_W-1:0]      out_target,
  output logic                  out_illegal
);

  br_fields_t      fields;
  logic [NFIB-1:0] cond_a;
  logic [NFIB-1:0] cond_b;
  logic            nx_taken;
  logic [NFIB-1:0] nx_mask;
  logic            nx_illegal;

  pbe_decode u_decode (
    .instr  (in_instr),
    .fields (fields)
  );

  pbe_lane_cond #(.NFIB(NFIB)) u_lanes (
    .pred   (in_pred),
    .inv_a  (fields.inv_a),
    .sel_a  (fields.sel_a),
    .inv_b  (fields.inv_b),
    .sel_b  (fields.sel_b),
    .cond_a (cond_a),
    .cond_b (cond_b)
  );

  pbe_reduce #(.NFIB(NFIB)) u_reduce (
    .is_branch (fields.is_branch),
    .kind_raw  (fields.kind_raw),
    .cond_a    (cond_a),
    .cond_b    (cond_b),
    .active    (in_active),
    .taken     (nx_taken),
    .mask      (nx_mask),
    .illegal   (nx_illegal)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_taken   <= 1'b0;
      out_mask    <= '0;
      out_target  <= '0;
      out_illegal <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken   <= nx_taken;
        out_mask    <= nx_mask;
        out_target  <= fields.target;
        out_illegal <= nx_illegal;
      end
    end
  end

endmodule

// File: rtl/pbe_checker.sv
module pbe_checker #(
  parameter int NFIB = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [63:0]     in_instr,
  input logic [NFIB-1:0] in_active,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_taken,
  input logic [NFIB-1:0] out_mask,
  input logic [31:0]     out_target,
  input logic            out_illegal
);

  logic accept;
  logic is_br;
  logic all_empty;

  assign accept    = in_valid && in_ready;
  assign is_br     = (in_instr[63:61] == 3'b000) && !in_instr[49] &&
                     (in_instr[58:55] == 4'b0001);
  assign all_empty = is_br && (in_instr[39:37] == 3'b101) && (in_active == '0);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  // R2
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_taken) &&
      $stable(out_mask) && $stable(out_target) && $stable(out_illegal)));

  // R11
  target_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_target == $past(in_instr[31:0])));

  // R3
  non_branch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_br) |=> (!out_taken && !out_illegal && out_mask == '0));

  // R10
  illegal_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_taken && out_mask == '0));

  // R5
  taken_matches_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_taken == (out_mask != '0)));

  // R7
  all_empty_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && all_empty) |=> !out_taken);

  logic unused_chk;
  assign unused_chk = ^{in_instr[60:59], in_instr[54:50], in_instr[48:40],
                        in_instr[36:32]};

endmodule

bind predicate_branch_eval pbe_checker #(.NFIB(NFIB)) u_pbe_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_instr    (in_instr),
  .in_active   (in_active),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_taken   (out_taken),
  .out_mask    (out_mask),
  .out_target  (out_target),
  .out_illegal (out_illegal)
);

// File: tb/predicate_branch_eval_test.sv
`timescale 1ns/1ps
module predicate_branch_eval_test;

  localparam int N  = 16;
  localparam int PW = 4 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [63:0]   in_instr = '0;
  logic [PW-1:0] in_pred = '0;
  logic [N-1:0]  in_active = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic          out_taken;
  logic [N-1:0]  out_mask;
  logic [31:0]   out_target;
  logic          out_illegal;

  int  nchk  = 0;
  int  nfail = 0;
  bit  done  = 1'b0;

  logic         q_tk[$];
  logic [N-1:0] q_m[$];
  logic         q_il[$];
  logic [31:0]  q_tg[$];
  string        q_tag[$];

  always #2 clk = ~clk;

  predicate_branch_eval #(.NFIB(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_pred(in_pred), .in_active(in_active),
    .out_valid(out_valid), .out_ready(out_ready), .out_taken(out_taken),
    .out_mask(out_mask), .out_target(out_target), .out_illegal(out_illegal)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Behavioural reference from the requirements
  task automatic model(input logic [63:0] w, input logic [PW-1:0] p,
                       input logic [N-1:0] a, output logic tk,
                       output logic [N-1:0] m, output logic il,
                       output string tag);
    int  s1, s2, nact, nhit;
    bit  i1, i2, c1, c2;
    tk = 0; m = '0; il = 0;
    s1 = int'(w[54:53]); i1 = w[52];
    s2 = int'(w[47:46]); i2 = w[45];
    nact = 0; nhit = 0;
    if (!(w[63:61] == 3'd0 && w[49] == 1'b0 && w[58:55] == 4'd1)) begin
      tag = "R3";
      return;
    end
    case (w[39:37])
      3'd0: tag = "R5/R4";
      3'd4: tag = "R6";
      3'd5: tag = "R7";
      3'd1: tag = "R8";
      3'd2: tag = "R9";
      default: tag = "R10";
    endcase
    for (int f = 0; f < N; f++) begin
      c1 = p[f*4 + s1] ^ i1;
      c2 = p[f*4 + s2] ^ i2;
      if (a[f]) nact++;
      if (a[f] && c1) nhit++;
      case (w[39:37])
        3'd0: m[f] = a[f] & c1;
        3'd1: m[f] = a[f] & (c1 | c2);
        3'd2: m[f] = a[f] & c1 & c2;
        default: ;
      endcase
    end
    case (w[39:37])
      3'd0, 3'd1, 3'd2: tk = (m != '0);
      3'd4: begin tk = (nhit > 0); m = tk ? a : '0; end
      3'd5: begin tk = (nact > 0) && (nhit == nact); m = tk ? a : '0; end
      default: il = 1;
    endcase
  endtask

  task automatic compare();
    check(out_valid == (q_tk.size() != 0), "R2", "out_valid",
          64'(out_valid), 64'(q_tk.size() != 0));
    if (out_valid && q_tk.size() != 0) begin
      check(out_taken == q_tk[0], q_tag[0], "taken", 64'(out_taken), 64'(q_tk[0]));
      check(out_mask == q_m[0], q_tag[0], "mask", 64'(out_mask), 64'(q_m[0]));
      check(out_illegal == q_il[0], q_tag[0], "illegal", 64'(out_illegal), 64'(q_il[0]));
      check(out_target == q_tg[0], "R11", "target", 64'(out_target), 64'(q_tg[0]));
    end
  endtask

  task automatic step(input logic v, input logic [63:0] w,
                      input logic [PW-1:0] p, input logic [N-1:0] a,
                      input logic rdy);
    logic         tk, il;
    logic [N-1:0] m;
    string        tag;
    @(negedge clk);
    compare();
    in_valid = v; in_instr = w; in_pred = p; in_active = a; out_ready = rdy;
    #1;
    check(in_ready == (q_tk.size() == 0 || rdy), "R2", "in_ready",
          64'(in_ready), 64'(q_tk.size() == 0 || rdy));
    if (out_valid && out_ready) begin
      void'(q_tk.pop_front()); void'(q_m.pop_front()); void'(q_il.pop_front());
      void'(q_tg.pop_front()); void'(q_tag.pop_front());
    end
    if (in_valid && in_ready) begin
      model(w, p, a, tk, m, il, tag);
      q_tk.push_back(tk); q_m.push_back(m); q_il.push_back(il);
      q_tg.push_back(w[31:0]); q_tag.push_back(tag);
    end
  endtask

  function automatic logic [63:0] mk(input logic [2:0] typ, input int s1,
                                     input bit i1, input int s2, input bit i2,
                                     input logic [31:0] tgt);
    logic [63:0] w = '0;
    w[58:55] = 4'b0001;
    w[39:37] = typ;
    w[54:53] = 2'(s1); w[52] = i1;
    w[47:46] = 2'(s2); w[45] = i2;
    w[31:0]  = tgt;
    return w;
  endfunction

  // Component c set on fibers in 'fib', other components random
  function automatic logic [PW-1:0] comp_pat(input int c, input logic [N-1:0] fib);
    logic [PW-1:0] p = {$urandom, $urandom};
    for (int f = 0; f < N; f++) p[f*4 + c] = fib[f];
    return p;
  endfunction

  initial begin : main
    logic [63:0]   w;
    logic [PW-1:0] p;
    logic [N-1:0]  a;
    int            s1;
    bit            i1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);

    // R4: every component select with and without inversion, per-fiber type
    for (int c = 0; c < 4; c++) begin
      for (int inv = 0; inv < 2; inv++) begin
        step(1, mk(3'b000, c, inv[0], 0, 0, 32'h1000 + 32'(c)),
             comp_pat(c, 16'h5A3C), 16'hFFF0, 1);
      end
    end
    // R6 any: one active hit, then hits only on inactive fibers
    step(1, mk(3'b100, 1, 0, 0, 0, 32'hA0), comp_pat(1, 16'h0100), 16'h0F00, 1);
    step(1, mk(3'b100, 1, 0, 0, 0, 32'hA1), comp_pat(1, 16'hF0FF), 16'h0F00, 1);
    step(1, mk(3'b100, 1, 0, 0, 0, 32'hA2), comp_pat(1, 16'hFFFF), 16'h0000, 1);
    // R7 all: true on active only, one active miss, empty active mask
    step(1, mk(3'b101, 2, 0, 0, 0, 32'hB0), comp_pat(2, 16'h00F0), 16'h00F0, 1);
    step(1, mk(3'b101, 2, 0, 0, 0, 32'hB1), comp_pat(2, 16'h00E0), 16'h00F0, 1);
    step(1, mk(3'b101, 2, 1, 0, 0, 32'hB2), comp_pat(2, 16'h0000), 16'h0000, 1);
    // R8 / R9 dual source
    p = comp_pat(0, 16'h00FF);
    for (int f = 0; f < N; f++) p[f*4 + 3] = (f % 3 == 0);
    step(1, mk(3'b001, 0, 0, 3, 1, 32'hC0), p, 16'hFFFF, 1);
    step(1, mk(3'b010, 0, 0, 3, 0, 32'hC1), p, 16'hFFFF, 1);
    // R10 unevaluated types
    step(1, mk(3'b011, 0, 0, 0, 0, 32'hD0), '1, 16'hFFFF, 1);
    step(1, mk(3'b110, 0, 0, 0, 0, 32'hD1), '1, 16'hFFFF, 1);
    step(1, mk(3'b111, 0, 0, 0, 0, 32'hD2), '1, 16'hFFFF, 1);
    // R3 near-miss opcodes
    w = mk(3'b000, 0, 0, 0, 0, 32'hE0); w[49] = 1'b1;
    step(1, w, '1, 16'hFFFF, 1);
    w = mk(3'b000, 0, 0, 0, 0, 32'hE1); w[61] = 1'b1;
    step(1, w, '1, 16'hFFFF, 1);
    w = mk(3'b000, 0, 0, 0, 0, 32'hE2); w[58:55] = 4'b0011;
    step(1, w, '1, 16'hFFFF, 1);
    // R2 stall with a word waiting, then drain
    step(1, mk(3'b000, 0, 0, 0, 0, 32'hF0), '1, 16'hFFFF, 0);
    step(1, mk(3'b000, 0, 0, 0, 0, 32'hF1), '0, 16'hFFFF, 0);
    step(1, mk(3'b000, 0, 0, 0, 0, 32'hF1), '0, 16'hFFFF, 0);
    step(0, '0, '0, '0, 1);
    step(0, '0, '0, '0, 1);

    // Random traffic with back-pressure
    for (int k = 0; k < 3000; k++) begin
      s1 = int'($urandom % 4);
      i1 = 1'($urandom);
      a  = N'($urandom);
      if ($urandom % 5 == 0) begin
        w = {$urandom, $urandom};
        if (w[63:61] == 3'd0 && !w[49] && w[58:55] == 4'd1) w[61] = 1'b1;
      end else begin
        w = mk(3'($urandom), s1, i1, int'($urandom % 4), 1'($urandom), $urandom);
        w[36:32] = 5'($urandom); w[44:40] = 5'($urandom);
        w[48] = 1'($urandom); w[51:50] = 2'($urandom); w[60:59] = 2'($urandom);
      end
      p = {$urandom, $urandom};
      if ($urandom % 2 == 0) begin
        for (int f = 0; f < N; f++) p[f*4 + s1] = a[f] ? !i1 : i1;
      end
      step(1'($urandom % 4 != 0), w, p, a, 1'($urandom % 10 < 7));
    end
    step(0, '0, '0, '0, 1);
    step(0, '0, '0, '0, 1);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : watchdog
    #(4.0 * 200000);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R2: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule